// File: doc/BRIEF.md
# Color-Bitmap Prefix Cross-Filter

This block sits between a set of independent per-field prefix lookups and the rule search stage of a multi-field packet classifier. Each field lookup hands over one candidate per color: the longest matching prefix of that color, with its identifier, its length and a valid bit. Each field lookup also returns, for every other field, a bitmap of the colors that field may combine with. The block uses these bitmaps to discard prefix combinations that no rule can produce, so that rule search only sees combinations that can occur.

For every field (dimension), the block gathers the colors that are actually present. It keeps only the colors that every other dimension allows, and picks the longest surviving prefix. If some dimension is left with no surviving color, the packet cannot match any rule and a no-match flag is raised in place of a prefix vector. The block is a four-stage pipeline that accepts a new packet on every clock. The stream carries only a valid qualifier and has no ready signal. Nothing downstream can stall it, so results must be consumed as they leave. The number of dimensions, the number of colors and the identifier and length widths are parameters.

Top module: `ccf_color_filter`

## Requirements
- R1: In dimension d, color c counts as present only when `in_pfx_vld[d*NCOL+c]` is 1. A color whose valid bit is 0 is never selected, whatever its length and allowance.
- R2: The surviving colors of dimension d are its present colors ANDed with `in_allow[(s*NDIM+d)*NCOL +: NCOL]` for every source dimension s other than d. Clearing one bit in any single source bitmap removes that color.
- R3: The self-directed bitmaps `in_allow[(d*NDIM+d)*NCOL +: NCOL]` have no effect on the result.
- R4: If any dimension has no surviving color, `out_nomatch` is 1 with `out_valid`, and `out_id`, `out_len` and `out_color` are all zero.
- R5: Otherwise, for each dimension d, `out_id`, `out_len` and `out_color` (slices of IDW, LENW and CW bits at d) carry the identifier, length and color index of the surviving color with the greatest length.
- R6: When several surviving colors of a dimension share the greatest length, the one with the lowest color index is selected.
- R7: A packet presented with `in_valid` high on a rising edge appears with `out_valid` high after exactly four register stages. Packets may arrive on consecutive cycles, and each one is delivered with no gaps and no loss.
- R8: A cycle whose input has `in_valid` low produces, four stages later, `out_valid` 0, `out_nomatch` 0 and all-zero data outputs, whatever the data inputs held.
- R9: While `rst_n` is low, `out_valid` and `out_nomatch` are 0, and inputs presented during reset produce no output.
- R10: Take dimension 0 with color 0 at length 0 and color 1 at length 3, allowing colors {0,1} of dimension 1. Take dimension 1 with color 0 at length 0 and color 1 at length 2, allowing only color 0 of dimension 0, with all other bitmaps fully set. Then dimension 0 yields its color-0 prefix and dimension 1 its color-1 prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input packet qualifier |
| in_pfx_vld | input | NDIM*NCOL | Per dimension and color: lookup returned a prefix |
| in_pfx_id | input | NDIM*NCOL*IDW | Per dimension and color: prefix identifier |
| in_pfx_len | input | NDIM*NCOL*LENW | Per dimension and color: prefix length |
| in_allow | input | NDIM*NDIM*NCOL | Allowed colors from source s toward target d at slice (s*NDIM+d)*NCOL |
| out_valid | output | 1 | Output packet qualifier |
| out_nomatch | output | 1 | No rule can match this packet |
| out_id | output | NDIM*IDW | Selected prefix identifier per dimension |
| out_len | output | NDIM*LENW | Selected prefix length per dimension |
| out_color | output | NDIM*CW | Selected color index per dimension |

## Verification
Every result, including the qualifier, the no-match flag and the per-dimension selections, is due four rising edges after the edge that samples the input. There are no other paths with a shorter or longer latency. The bench drives inputs at the falling edge and computes the expected outputs at that same moment. It files them in an eight-entry ring and compares each entry at the falling edge that follows the fourth rising edge. This means that, in every cycle, the bench checks the packet driven four cycles earlier, including the idle and reset-drain cycles. Random streams with gaps and back-to-back packets run alongside directed cases for ties, invalid long prefixes, single-source masking, self bitmaps, forced no-match and the two-field worked case.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

  // Width of an index that selects one of n items (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ccf_allow_merge.sv
// Stage 1: per target dimension, AND together the allowed-color bitmaps sent
// by every other dimension; register the present colors and prefix data.
module ccf_allow_merge #(
  parameter int NDIM = 5,
  parameter int NCOL = 8,
  parameter int IDW  = 12,
  parameter int LENW = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NDIM*NCOL-1:0]      in_pfx_vld,
  input  logic [NDIM*NCOL*IDW-1:0]  in_pfx_id,
  input  logic [NDIM*NCOL*LENW-1:0] in_pfx_len,
  input  logic [NDIM*NDIM*NCOL-1:0] in_allow,
  output logic                      s1_valid,
  output logic [NDIM*NCOL-1:0]      s1_pcb,
  output logic [NDIM*NCOL-1:0]      s1_mask,
  output logic [NDIM*NCOL*IDW-1:0]  s1_id,
  output logic [NDIM*NCOL*LENW-1:0] s1_len
);

  logic [NDIM*NCOL-1:0] mask_nxt;

  for (genvar d = 0; d < NDIM; d++) begin : g_tgt
    logic [NCOL-1:0] acc;
    always_comb begin
      acc = '1;
      for (int s = 0; s < NDIM; s++) begin
        acc &= (s == d) ? {NCOL{1'b1}} : in_allow[(s*NDIM+d)*NCOL +: NCOL];
      end
    end
    assign mask_nxt[d*NCOL +: NCOL] = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pcb   <= '0;
      s1_mask  <= '0;
      s1_id    <= '0;
      s1_len   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_pcb   <= in_pfx_vld;
      s1_mask  <= mask_nxt;
      s1_id    <= in_pfx_id;
      s1_len   <= in_pfx_len;
    end
  end

endmodule

// File: rtl/ccf_mask.sv
// Stage 2: final allowed colors per dimension and the packet-wide dead flag.
module ccf_mask #(
  parameter int NDIM = 5,
  parameter int NCOL = 8,
  parameter int IDW  = 12,
  parameter int LENW = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s1_valid,
  input  logic [NDIM*NCOL-1:0]      s1_pcb,
  input  logic [NDIM*NCOL-1:0]      s1_mask,
  input  logic [NDIM*NCOL*IDW-1:0]  s1_id,
  input  logic [NDIM*NCOL*LENW-1:0] s1_len,
  output logic                      s2_valid,
  output logic                      s2_dead,
  output logic [NDIM*NCOL-1:0]      s2_facb,
  output logic [NDIM*NCOL*IDW-1:0]  s2_id,
  output logic [NDIM*NCOL*LENW-1:0] s2_len
);

  logic [NDIM*NCOL-1:0] facb_nxt;
  logic [NDIM-1:0]      empty;

  assign facb_nxt = s1_pcb & s1_mask;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    assign empty[d] = ~|facb_nxt[d*NCOL +: NCOL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_dead  <= 1'b0;
      s2_facb  <= '0;
      s2_id    <= '0;
      s2_len   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_dead  <= |empty;
      s2_facb  <= facb_nxt;
      s2_id    <= s1_id;
      s2_len   <= s1_len;
    end
  end

endmodule

// File: rtl/ccf_select.sv
// Stage 3: per dimension, longest surviving prefix; ties go to the lowest color.
module ccf_select #(
  parameter int NDIM = 5,
  parameter int NCOL = 8,
  parameter int IDW  = 12,
  parameter int LENW = 6,
  parameter int CW   = ccf_pkg::idx_width(NCOL)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s2_valid,
  input  logic                      s2_dead,
  input  logic [NDIM*NCOL-1:0]      s2_facb,
  input  logic [NDIM*NCOL*IDW-1:0]  s2_id,
  input  logic [NDIM*NCOL*LENW-1:0] s2_len,
  output logic                      s3_valid,
  output logic                      s3_dead,
  output logic [NDIM*IDW-1:0]       s3_id,
  output logic [NDIM*LENW-1:0]      s3_len,
  output logic [NDIM*CW-1:0]        s3_col
);

  logic [NDIM*IDW-1:0]  id_nxt;
  logic [NDIM*LENW-1:0] len_nxt;
  logic [NDIM*CW-1:0]   col_nxt;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    logic [NCOL-1:0] fa;
    logic [IDW-1:0]  b_id;
    logic [LENW-1:0] b_len;
    logic [CW-1:0]   b_col;
    logic            b_hit;

    assign fa = s2_facb[d*NCOL +: NCOL];

    always_comb begin
      b_id  = '0;
      b_len = '0;
      b_col = '0;
      b_hit = 1'b0;
      for (int c = 0; c < NCOL; c++) begin
        if (fa[c] && (!b_hit || (s2_len[(d*NCOL+c)*LENW +: LENW] > b_len))) begin
          b_hit = 1'b1;
          b_len = s2_len[(d*NCOL+c)*LENW +: LENW];
          b_id  = s2_id[(d*NCOL+c)*IDW +: IDW];
          b_col = CW'(c);
        end
      end
    end

    assign id_nxt[d*IDW +: IDW]    = b_id;
    assign len_nxt[d*LENW +: LENW] = b_len;
    assign col_nxt[d*CW +: CW]     = b_col;

    // R4: a live packet leaves the mask stage only if every dimension has a survivor
    a_r4_dead_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !s2_dead) |-> b_hit);

    // R1: the picked color is one that survived the mask
    a_r1_pick_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && b_hit) |-> fa[b_col]);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic [LENW-1:0] cl;
      assign cl = s2_len[(d*NCOL+c)*LENW +: LENW];

      // R5: no surviving color is longer than the pick
      a_r5_longest: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && fa[c]) |-> (cl <= b_len));

      // R6: a lower-index survivor must be strictly shorter than the pick
      a_r6_low_index_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && fa[c] && (CW'(c) < b_col)) |-> (cl < b_len));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
      s3_dead  <= 1'b0;
      s3_id    <= '0;
      s3_len   <= '0;
      s3_col   <= '0;
    end else begin
      s3_valid <= s2_valid;
      s3_dead  <= s2_dead;
      s3_id    <= id_nxt;
      s3_len   <= len_nxt;
      s3_col   <= col_nxt;
    end
  end

endmodule

// File: rtl/ccf_color_filter.sv
// Top: three processing stages plus an output stage that zeroes the data of
// idle and no-match packets.
module ccf_color_filter #(
  parameter int NDIM = 5,
  parameter int NCOL = 8,
  parameter int IDW  = 12,
  parameter int LENW = 6,
  localparam int CW  = ccf_pkg::idx_width(NCOL)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NDIM*NCOL-1:0]      in_pfx_vld,
  input  logic [NDIM*NCOL*IDW-1:0]  in_pfx_id,
  input  logic [NDIM*NCOL*LENW-1:0] in_pfx_len,
  input  logic [NDIM*NDIM*NCOL-1:0] in_allow,
  output logic                      out_valid,
  output logic                      out_nomatch,
  output logic [NDIM*IDW-1:0]       out_id,
  output logic [NDIM*LENW-1:0]      out_len,
  output logic [NDIM*CW-1:0]        out_color
);

  logic                      s1_valid;
  logic [NDIM*NCOL-1:0]      s1_pcb;
  logic [NDIM*NCOL-1:0]      s1_mask;
  logic [NDIM*NCOL*IDW-1:0]  s1_id;
  logic [NDIM*NCOL*LENW-1:0] s1_len;

  logic                      s2_valid;
  logic                      s2_dead;
  logic [NDIM*NCOL-1:0]      s2_facb;
  logic [NDIM*NCOL*IDW-1:0]  s2_id;
  logic [NDIM*NCOL*LENW-1:0] s2_len;

  logic                      s3_valid;
  logic                      s3_dead;
  logic [NDIM*IDW-1:0]       s3_id;
  logic [NDIM*LENW-1:0]      s3_len;
  logic [NDIM*CW-1:0]        s3_col;

  logic                      keep;

  ccf_allow_merge #(.NDIM(NDIM), .NCOL(NCOL), .IDW(IDW), .LENW(LENW)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pfx_vld(in_pfx_vld),
    .in_pfx_id (in_pfx_id),
    .in_pfx_len(in_pfx_len),
    .in_allow  (in_allow),
    .s1_valid  (s1_valid),
    .s1_pcb    (s1_pcb),
    .s1_mask   (s1_mask),
    .s1_id     (s1_id),
    .s1_len    (s1_len)
  );

  ccf_mask #(.NDIM(NDIM), .NCOL(NCOL), .IDW(IDW), .LENW(LENW)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_valid(s1_valid),
    .s1_pcb  (s1_pcb),
    .s1_mask (s1_mask),
    .s1_id   (s1_id),
    .s1_len  (s1_len),
    .s2_valid(s2_valid),
    .s2_dead (s2_dead),
    .s2_facb (s2_facb),
    .s2_id   (s2_id),
    .s2_len  (s2_len)
  );

  ccf_select #(.NDIM(NDIM), .NCOL(NCOL), .IDW(IDW), .LENW(LENW), .CW(CW)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .s2_valid(s2_valid),
    .s2_dead (s2_dead),
    .s2_facb (s2_facb),
    .s2_id   (s2_id),
    .s2_len  (s2_len),
    .s3_valid(s3_valid),
    .s3_dead (s3_dead),
    .s3_id   (s3_id),
    .s3_len  (s3_len),
    .s3_col  (s3_col)
  );

  assign keep = s3_valid && !s3_dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_nomatch <= 1'b0;
      out_id      <= '0;
      out_len     <= '0;
      out_color   <= '0;
    end else begin
      out_valid   <= s3_valid;
      out_nomatch <= s3_valid && s3_dead;
      out_id      <= keep ? s3_id  : '0;
      out_len     <= keep ? s3_len : '0;
      out_color   <= keep ? s3_col : '0;
    end
  end

  // R4: a no-match result never carries prefix data
  a_r4_nomatch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_nomatch |-> (out_id == '0 && out_len == '0 && out_color == '0));

  // R8: idle output slots carry no flag and no data
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_nomatch && out_id == '0));

endmodule

// File: tb/tb_ccf_color_filter.sv
`timescale 1ns/1ps
module tb_ccf_color_filter;

  localparam int ND = 5;
  localparam int NC = 8;
  localparam int IW = 12;
  localparam int LW = 6;
  localparam int CW = ccf_pkg::idx_width(NC);

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  in_valid;
  logic [ND*NC-1:0]      p_vld;
  logic [ND*NC*IW-1:0]   p_id;
  logic [ND*NC*LW-1:0]   p_len;
  logic [ND*ND*NC-1:0]   p_allow;
  logic                  out_valid;
  logic                  out_nomatch;
  logic [ND*IW-1:0]      out_id;
  logic [ND*LW-1:0]      out_len;
  logic [ND*CW-1:0]      out_color;

  always #4 clk = ~clk;

  ccf_color_filter #(.NDIM(ND), .NCOL(NC), .IDW(IW), .LENW(LW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_pfx_vld (p_vld),
    .in_pfx_id  (p_id),
    .in_pfx_len (p_len),
    .in_allow   (p_allow),
    .out_valid  (out_valid),
    .out_nomatch(out_nomatch),
    .out_id     (out_id),
    .out_len    (out_len),
    .out_color  (out_color)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  logic             e_v   [8];
  logic             e_nm  [8];
  logic [ND*IW-1:0] e_id  [8];
  logic [ND*LW-1:0] e_len [8];
  logic [ND*CW-1:0] e_col [8];
  string            e_tag [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected result straight from the requirements
  function automatic void ref_model(
      input  logic [ND*NC-1:0]    vld,
      input  logic [ND*NC*IW-1:0] id,
      input  logic [ND*NC*LW-1:0] ln,
      input  logic [ND*ND*NC-1:0] al,
      output logic                nm,
      output logic [ND*IW-1:0]    oid,
      output logic [ND*LW-1:0]    olen,
      output logic [ND*CW-1:0]    ocol);
    nm = 0; oid = '0; olen = '0; ocol = '0;
    for (int d = 0; d < ND; d++) begin
      logic [NC-1:0] fin;
      int best;
      fin = vld[d*NC +: NC];
      for (int s = 0; s < ND; s++)
        if (s != d) fin = fin & al[(s*ND+d)*NC +: NC];
      if (fin == '0) nm = 1;
      best = -1;
      for (int c = NC-1; c >= 0; c--)
        if (fin[c] && (best < 0 || ln[(d*NC+c)*LW +: LW] >= ln[(d*NC+best)*LW +: LW]))
          best = c;
      if (best >= 0) begin
        oid[d*IW +: IW]  = id[(d*NC+best)*IW +: IW];
        olen[d*LW +: LW] = ln[(d*NC+best)*LW +: LW];
        ocol[d*CW +: CW] = CW'(best);
      end
    end
    if (nm) begin oid = '0; olen = '0; ocol = '0; end
  endfunction

  task automatic check_slot(input int s);
    chk(out_valid === e_v[s], "R7", "out_valid", 64'(out_valid), 64'(e_v[s]));
    if (e_v[s]) begin
      chk(out_nomatch === e_nm[s], e_tag[s], "out_nomatch", 64'(out_nomatch), 64'(e_nm[s]));
      chk(out_id    === e_id[s],  e_tag[s], "out_id",    64'(out_id),    64'(e_id[s]));
      chk(out_len   === e_len[s], e_tag[s], "out_len",   64'(out_len),   64'(e_len[s]));
      chk(out_color === e_col[s], e_tag[s], "out_color", 64'(out_color), 64'(e_col[s]));
    end else begin
      chk(out_nomatch === 1'b0 && out_id === '0 && out_len === '0 && out_color === '0,
          "R8", "idle outputs", {out_nomatch, out_id}, 64'd0);
    end
  endtask

  // Present the current p_* for one cycle, then check the packet due now
  task automatic push(input logic v, input string tag);
    logic             nm;
    logic [ND*IW-1:0] oid;
    logic [ND*LW-1:0] olen;
    logic [ND*CW-1:0] ocol;
    int s;
    ref_model(p_vld, p_id, p_len, p_allow, nm, oid, olen, ocol);
    s = cyc % 8;
    in_valid = v;
    e_v[s]   = v;
    e_nm[s]  = v & nm;
    e_id[s]  = v ? oid  : '0;
    e_len[s] = v ? olen : '0;
    e_col[s] = v ? ocol : '0;
    e_tag[s] = (tag != "") ? tag : (nm ? "R4" : "R5");
    @(negedge clk);
    check_slot((cyc + 5) % 8);
    cyc++;
  endtask

  task automatic rand_pkt(input bit sparse);
    for (int i = 0; i < ND*NC; i++) begin
      p_vld[i]           = 1'($urandom_range(0, 1));
      p_id[i*IW +: IW]   = IW'($urandom);
      p_len[i*LW +: LW]  = LW'($urandom_range(0, 7));
    end
    for (int i = 0; i < ND*ND; i++)
      p_allow[i*NC +: NC] = sparse ? NC'($urandom & $urandom)
                                   : NC'($urandom | $urandom | $urandom);
  endtask

  task automatic base_pkt();
    p_vld = '0; p_id = '0; p_len = '0; p_allow = '1;
    for (int d = 0; d < ND; d++) begin
      p_vld[d*NC]                 = 1'b1;
      p_id[(d*NC)*IW +: IW]       = IW'((d + 1) << 8);
      p_len[(d*NC)*LW +: LW]      = LW'(d);
    end
  endtask

  task automatic setp(input int d, input int c, input int id, input int ln);
    p_vld[d*NC+c]            = 1'b1;
    p_id[(d*NC+c)*IW +: IW]  = IW'(id);
    p_len[(d*NC+c)*LW +: LW] = LW'(ln);
  endtask

  task automatic seta(input int s, input int d, input logic [NC-1:0] m);
    p_allow[(s*ND+d)*NC +: NC] = m;
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) begin
      e_v[i] = 0; e_nm[i] = 0; e_id[i] = '0; e_len[i] = '0; e_col[i] = '0; e_tag[i] = "R8";
    end
    rst_n = 1'b0;
    in_valid = 1'b1;          // R9: driven during reset, must be dropped
    rand_pkt(1'b0);
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(out_nomatch === 1'b0, "R9", "out_nomatch in reset", 64'(out_nomatch), 64'd0);
    rst_n = 1'b1;

    // R10: two-field worked case
    base_pkt();
    setp(0, 0, 12'h101, 0); setp(0, 1, 12'h102, 3);
    setp(1, 0, 12'h201, 0); setp(1, 1, 12'h202, 2);
    seta(1, 0, 8'h01); seta(0, 1, 8'h03);
    push(1'b1, "R10");

    // R6: equal lengths, lower color must win
    base_pkt();
    setp(0, 2, 12'h0A2, 7); setp(0, 5, 12'h0A5, 7);
    push(1'b1, "R6");

    // R1: long but invalid color must be ignored
    base_pkt();
    setp(0, 3, 12'h033, 5);
    p_id[(0*NC+6)*IW +: IW] = 12'h066; p_len[(0*NC+6)*LW +: LW] = 6'd60;
    push(1'b1, "R1");

    // R2: one source clears one color
    base_pkt();
    setp(0, 4, 12'h044, 30); setp(0, 1, 12'h011, 10);
    seta(3, 0, ~8'h10);
    push(1'b1, "R2");

    // R3: self bitmaps all zero, no effect
    base_pkt();
    setp(2, 3, 12'h323, 9);
    for (int d = 0; d < ND; d++) seta(d, d, 8'h00);
    push(1'b1, "R3");

    // R4: one source empties a target dimension
    base_pkt();
    setp(4, 2, 12'h542, 11);
    seta(2, 4, 8'h00);
    push(1'b1, "R4");

    // R8: idle with junk data
    rand_pkt(1'b0);
    push(1'b0, "R8");

    // R7 / R5 / R4: random stream with gaps and back-to-back runs
    for (int t = 0; t < 1500; t++) begin
      rand_pkt($urandom_range(0, 5) == 0);
      push($urandom_range(0, 9) != 0, "");
    end

    repeat (5) begin
      rand_pkt(1'b0);
      push(1'b0, "R8");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule